// File: doc/BRIEF.md
# Address-Strobed Set/Clear Control Register Bank

This block holds a sixteen-bit bank of system control bits that a processor programs using only the address of a write cycle. No data bus reaches the block. Each control bit owns a pair of adjacent addresses inside a 32-byte window at the top of the memory map. A write to the even address of the pair clears the bit, and a write to the odd address sets it. Software therefore changes any single bit with one store, and the value stored does not matter.

The bits form six fields: a video address mode, a display start offset in 512-byte steps, a page select, a processor clock-rate mode, a memory-size code and a map-type bit. The block also computes two values each cycle from the current bus address. The first is a fast/slow select for the clock generator, which depends on the rate mode and, in the dual-rate mode, on the address region. The second is a redirected address that moves the top interrupt-vector locations down into the low program ROM.

Top module: `strobe_ctl_bank`

## Requirements
- R1: After a synchronous reset every control bit is 0, so the video mode, offset, page, rate mode, memory size and map type all read 0, the display base is 0000, and `fast_sel` is 0 for any address.
- R2: A write (`cpu_valid`=1, `cpu_we`=1) to address FFC0 + 2k + 1, with k from 0 to 15, sets control bit k. The new value appears on the field outputs after the next rising clock edge. Bit k maps as follows: k=0..2 video mode bits 0..2, k=3..9 offset bits 0..6, k=10 page, k=11..12 rate mode bits 0..1, k=13..14 memory size bits 0..1, k=15 map type.
- R3: A write to the even address FFC0 + 2k clears control bit k, using the same bit mapping as R2.
- R4: Reads inside the window, and writes outside FFC0–FFDF (for example FFBF or FFE1), leave every control bit unchanged.
- R5: `disp_base` equals the 7-bit offset field multiplied by 512, that is, the offset placed at address bits 15..9 with bits 8..0 zero.
- R6: With rate mode 0, `fast_sel` is 0 for every address.
- R7: With rate mode 2 or 3, `fast_sel` is 1 for every address.
- R8: With rate mode 1, `fast_sel` is 0 for addresses 0000–7FFF and FF00–FF1F, and 1 for all other addresses, including 8000, FEFF and FF20.
- R9: `mapped_addr` equals `cpu_addr` with bit 14 cleared when `cpu_addr` lies in FFF2–FFFF, so FFF2–FFFF becomes BFF2–BFFF. For any other address it equals `cpu_addr` unchanged.
- R10: A set or clear strobe changes only its own bit, and repeating a strobe leaves the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | Address of the current bus cycle |
| cpu_valid | input | 1 | A bus cycle is in progress |
| cpu_we | input | 1 | The current cycle is a write |
| video_mode | output | 3 | Video address mode field |
| disp_offset | output | 7 | Display offset field, in 512-byte units |
| disp_base | output | 16 | Display start address |
| page_sel | output | 1 | Upper/lower 32 KB page select |
| rate_mode | output | 2 | Clock-rate mode field |
| mem_size | output | 2 | Memory device size code |
| map_type | output | 1 | Map-type bit |
| fast_sel | output | 1 | 1 = fast processor clock for this cycle |
| mapped_addr | output | 16 | Address after vector redirection |

## Verification
The assertions assume that `cpu_addr`, `cpu_we` and `cpu_valid` are stable for a whole clock period and are never X once reset is released. They also assume that a write strobe is a single-cycle event, so that the bit named by the previous cycle's address is the only one that may change. The bench drives all inputs on the falling edge and holds each write for exactly one clock, then drops `cpu_valid`. It tests each address-dependent output only after the rate mode has settled. The write sequence covers both parities, the window edges, and addresses just outside the window.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int ADDR_W   = 16;
    localparam int NBITS    = 16;
    localparam int IDX_W    = $clog2(NBITS);
    localparam int WIN_LSB  = IDX_W + 1;

    localparam logic [ADDR_W-1:0] WIN_BASE    = 16'hFFC0;
    localparam logic [ADDR_W-1:0] SLOW_IO_LO  = 16'hFF00;
    localparam int                SLOW_IO_LSB = 5;
    localparam logic [ADDR_W-1:0] VEC_LO      = 16'hFFF2;
    localparam int                VEC_DROP    = 14;
    localparam int                PAGE_SHIFT  = 9;

    typedef enum logic [1:0] {
        RATE_SLOW     = 2'd0,
        RATE_DUAL     = 2'd1,
        RATE_FAST     = 2'd2,
        RATE_FAST_ALT = 2'd3
    } rate_e;

    // Packed MSB-first so that bit k of the bank lines up with the strobe index k.
    typedef struct packed {
        logic       map_type;
        logic [1:0] mem_size;
        rate_e      rate;
        logic       page;
        logic [6:0] offset;
        logic [2:0] vmode;
    } ctl_t;

    function automatic logic in_window(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:WIN_LSB] == WIN_BASE[ADDR_W-1:WIN_LSB];
    endfunction

    function automatic logic slow_region(input logic [ADDR_W-1:0] a);
        return (a[ADDR_W-1] == 1'b0) ||
               (a[ADDR_W-1:SLOW_IO_LSB] == SLOW_IO_LO[ADDR_W-1:SLOW_IO_LSB]);
    endfunction

    function automatic logic [ADDR_W-1:0] redirect(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        r = a;
        if (a >= VEC_LO) r[VEC_DROP] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sc_bit_bank.sv
module sc_bit_bank
    import sc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    output logic [NBITS-1:0]  bits
);

    logic             strobe;
    logic [IDX_W-1:0] sel;
    logic             level;

    always_comb begin
        strobe = cpu_valid && cpu_we && in_window(cpu_addr);
        sel    = cpu_addr[IDX_W:1];
        level  = cpu_addr[0];
    end

    for (genvar k = 0; k < NBITS; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits[k] <= 1'b0;
            else if (strobe && (sel == IDX_W'(k)))
                bits[k] <= level;
        end
    end

    assert_set_R2: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && in_window(cpu_addr) && cpu_addr[0])
            |=> bits[$past(cpu_addr[IDX_W:1])] == 1'b1);

    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && in_window(cpu_addr) && !cpu_addr[0])
            |=> bits[$past(cpu_addr[IDX_W:1])] == 1'b0);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(cpu_valid && cpu_we && in_window(cpu_addr)) |=> $stable(bits));

    assert_single_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_valid && cpu_we && in_window(cpu_addr))
            |=> $countones(bits ^ $past(bits)) <= 1);

endmodule

// File: rtl/sc_rate_pick.sv
module sc_rate_pick
    import sc_pkg::*;
(
    input  rate_e             mode,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              fast_sel
);

    always_comb begin
        unique case (mode)
            RATE_SLOW:     fast_sel = 1'b0;
            RATE_DUAL:     fast_sel = !slow_region(cpu_addr);
            RATE_FAST,
            RATE_FAST_ALT: fast_sel = 1'b1;
            default:       fast_sel = 1'b0;
        endcase
    end

endmodule

// File: rtl/sc_vec_remap.sv
module sc_vec_remap
    import sc_pkg::*;
(
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] mapped_addr
);

    always_comb mapped_addr = redirect(cpu_addr);

endmodule

// File: rtl/strobe_ctl_bank.sv
module strobe_ctl_bank
    import sc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_valid,
    input  logic        cpu_we,
    output logic [2:0]  video_mode,
    output logic [6:0]  disp_offset,
    output logic [15:0] disp_base,
    output logic        page_sel,
    output logic [1:0]  rate_mode,
    output logic [1:0]  mem_size,
    output logic        map_type,
    output logic        fast_sel,
    output logic [15:0] mapped_addr
);

    logic [NBITS-1:0] bank;
    ctl_t             ctl;

    sc_bit_bank u_bank (
        .clk       (clk),
        .rst       (rst),
        .cpu_addr  (cpu_addr),
        .cpu_valid (cpu_valid),
        .cpu_we    (cpu_we),
        .bits      (bank)
    );

    always_comb begin
        ctl         = ctl_t'(bank);
        video_mode  = ctl.vmode;
        disp_offset = ctl.offset;
        disp_base   = {ctl.offset, {PAGE_SHIFT{1'b0}}};
        page_sel    = ctl.page;
        rate_mode   = ctl.rate;
        mem_size    = ctl.mem_size;
        map_type    = ctl.map_type;
    end

    sc_rate_pick u_rate (
        .mode     (ctl.rate),
        .cpu_addr (cpu_addr),
        .fast_sel (fast_sel)
    );

    sc_vec_remap u_remap (
        .cpu_addr    (cpu_addr),
        .mapped_addr (mapped_addr)
    );

    assert_fixed_slow_R6: assert property (@(posedge clk) disable iff (rst)
        (rate_mode == 2'd0) |-> !fast_sel);

    assert_fixed_fast_R7: assert property (@(posedge clk) disable iff (rst)
        rate_mode[1] |-> fast_sel);

    assert_low_half_slow_R8: assert property (@(posedge clk) disable iff (rst)
        (rate_mode == 2'd1 && !cpu_addr[15]) |-> !fast_sel);

    assert_vector_move_R9: assert property (@(posedge clk) disable iff (rst)
        (cpu_addr[15:4] == 12'hFFF && cpu_addr[3:0] >= 4'h2)
            |-> (mapped_addr[15:12] == 4'hB && mapped_addr[11:0] == cpu_addr[11:0]));

    assert_base_R5: assert property (@(posedge clk) disable iff (rst)
        disp_base[8:0] == 9'd0 && disp_base[15:9] == disp_offset);

endmodule

// File: tb/strobe_ctl_bank_tb.sv
module strobe_ctl_bank_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 15;
    // {write, address, expected bank after the cycle}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b1, 16'hFFC1, 16'h0001},
        {1'b1, 16'hFFC5, 16'h0005},
        {1'b1, 16'hFFC7, 16'h000D},
        {1'b1, 16'hFFD3, 16'h020D},
        {1'b1, 16'hFFD5, 16'h060D},
        {1'b1, 16'hFFDF, 16'h860D},
        {1'b1, 16'hFFDB, 16'hA60D},
        {1'b1, 16'hFFC0, 16'hA60C},
        {1'b0, 16'hFFD3, 16'hA60C},
        {1'b1, 16'hFFE1, 16'hA60C},
        {1'b1, 16'hFFBF, 16'hA60C},
        {1'b1, 16'hFFD4, 16'hA20C},
        {1'b1, 16'hFFDE, 16'h220C},
        {1'b1, 16'hFFC1, 16'h220D},
        {1'b1, 16'hFFC1, 16'h220D}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_valid = 1'b0;
    logic        cpu_we = 1'b0;
    logic [2:0]  video_mode;
    logic [6:0]  disp_offset;
    logic [15:0] disp_base;
    logic        page_sel;
    logic [1:0]  rate_mode;
    logic [1:0]  mem_size;
    logic        map_type;
    logic        fast_sel;
    logic [15:0] mapped_addr;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    strobe_ctl_bank dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] bank_view();
        return {map_type, mem_size, rate_mode, page_sel, disp_offset, video_mode};
    endfunction

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic strobe(input logic wr, input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; cpu_we = wr; cpu_valid = 1'b1;
        @(negedge clk);
        cpu_valid = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic probe_rate(input string req, input logic [15:0] a, input logic exp);
        cpu_addr = a;
        #1;
        check16(req, {15'd0, fast_sel}, {15'd0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check16("R1 bank", bank_view(), 16'h0000);
        check16("R1 base", disp_base, 16'h0000);
        probe_rate("R1 rate", 16'hA000, 1'b0);

        // R2 R3 R4 R10: table walk
        for (int i = 0; i < NVEC; i++) begin
            strobe(VEC[i][32], VEC[i][31:16]);
            check16($sformatf("R2/R3/R4/R10 step %0d", i), bank_view(), VEC[i][15:0]);
            // R5: offset field is bits 9..3 of the expected bank
            check16($sformatf("R5 step %0d", i), disp_base, {VEC[i][9:3], 9'd0});
        end

        // R6: mode 0 is slow everywhere
        @(negedge clk);
        probe_rate("R6", 16'h0000, 1'b0);
        probe_rate("R6", 16'hC000, 1'b0);
        probe_rate("R6", 16'hFFFF, 1'b0);

        // R8: set R0 via FFD7
        strobe(1'b1, 16'hFFD7);
        check16("R8 mode", {14'd0, rate_mode}, 16'd1);
        probe_rate("R8 low", 16'h0000, 1'b0);
        probe_rate("R8 low top", 16'h7FFF, 1'b0);
        probe_rate("R8 rom", 16'h8000, 1'b1);
        probe_rate("R8 below io", 16'hFEFF, 1'b1);
        probe_rate("R8 io lo", 16'hFF00, 1'b0);
        probe_rate("R8 io hi", 16'hFF1F, 1'b0);
        probe_rate("R8 io next", 16'hFF20, 1'b1);

        // R7: mode 2 then mode 3
        strobe(1'b1, 16'hFFD6);
        strobe(1'b1, 16'hFFD9);
        check16("R7 mode2", {14'd0, rate_mode}, 16'd2);
        probe_rate("R7", 16'h0000, 1'b1);
        probe_rate("R7", 16'hFF10, 1'b1);
        strobe(1'b1, 16'hFFD7);
        check16("R7 mode3", {14'd0, rate_mode}, 16'd3);
        probe_rate("R7", 16'h1234, 1'b1);

        // R9: vector redirection
        cpu_addr = 16'hFFF2; #1; check16("R9 lo", mapped_addr, 16'hBFF2);
        cpu_addr = 16'hFFFE; #1; check16("R9 reset vec", mapped_addr, 16'hBFFE);
        cpu_addr = 16'hFFFF; #1; check16("R9 top", mapped_addr, 16'hBFFF);
        cpu_addr = 16'hFFF1; #1; check16("R9 below", mapped_addr, 16'hFFF1);
        cpu_addr = 16'hFFC0; #1; check16("R9 window", mapped_addr, 16'hFFC0);
        cpu_addr = 16'h4FF2; #1; check16("R9 low", mapped_addr, 16'h4FF2);

        // R1: reset again clears a loaded bank
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check16("R1 rereset", bank_view(), 16'h0000);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule